// File: doc/BRIEF.md
# Parity-Framed Byte Frame Codec

This block converts between a byte stream and the bit-serial frames used on a contactless card link. On the transmit side it takes bytes with an end marker and sends them as one frame. The frame opens with a single start bit. Each byte is sent least-significant bit first and is followed by an odd parity bit. When asked, the block appends a 16-bit CRC computed over the payload. A frame never grows past 163 bits. If the byte stream runs past that size, the frame is closed early and the remaining bytes start a new frame.

On the receive side the block takes one bit per valid/ready transfer, plus a marker on the final bit of the frame. It rebuilds each byte and hands complete bytes out in order. When the frame ends it reports one status word. The status flags a parity failure, a CRC failure, a bit count that is not one plus a multiple of nine, or a frame that exceeded the size limit. Modulation and line coding belong to neighbouring logic. The byte output honours backpressure by stalling the serial input.

Top module: `parity_frame_codec`

## Requirements
- R1: A transmitted frame starts with exactly one start bit of value 1. The bytes then follow in the order they were accepted, each sent bit 0 first. `tx_in_ready` is never high while a bit is offered on the line.
- R2: Every transmitted byte is followed by one parity bit. That bit makes the count of ones across the 8 data bits and the parity bit odd.
- R3: If `tx_in_crc` is high when a frame's first byte is presented, the frame carries a CRC after the payload. The CRC uses polynomial 0x8408 in reflected form with initial value 0x6363, is taken over the data bytes, and is sent low byte first; payload 00 00 gives A0 then 1E. `tx_line_end` is high on exactly the last bit of the frame, and the line is idle for at least the cycle after that bit.
- R4: A transmitted frame carries at most MAX_BYTES (18) bytes, CRC included, which is 163 bits. With the CRC off, the 18th data byte closes the frame; with the CRC on, the 16th does.
- R5: While `tx_line_valid` is high and `tx_line_ready` is low, the offered bit and end marker stay unchanged.
- R6: The receiver delivers every complete 9-bit byte, CRC bytes included, on `rx_out_data` in arrival order. A trailing partial byte is not delivered. One status pulse is produced per frame.
- R7: `rx_stat_par` is set if any received byte's 9 bits hold an even number of ones.
- R8: If `rx_crc_en` is high with the start bit, the CRC residue over all complete received bytes must be zero; otherwise `rx_stat_crc` is set. With `rx_crc_en` low, `rx_stat_crc` stays 0.
- R9: `rx_stat_len` is set when the frame's bit count, start bit included, is not 1 plus a multiple of 9.
- R10: A 164th received bit aborts the frame. It gives a status with `rx_stat_long`=1 and both length and CRC flags at 0. Later bits up to the end marker are accepted and ignored. A frame of exactly 163 bits is not flagged.
- R11: While a received byte is held and `rx_out_ready` is low, `rx_line_ready` is low and the held byte is unchanged. No byte is lost.
- R12: After reset, `tx_line_valid`, `tx_in_ready`, `rx_out_valid` and `rx_stat_valid` are 0 and `rx_line_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_data | input | 8 | Byte to transmit |
| tx_in_last | input | 1 | Byte is the last payload byte of its frame |
| tx_in_crc | input | 1 | Append CRC to the frame (sampled with its first byte) |
| tx_in_valid | input | 1 | Byte offered |
| tx_in_ready | output | 1 | Byte taken |
| tx_line_bit | output | 1 | Serial bit out |
| tx_line_end | output | 1 | Bit is the last of the frame |
| tx_line_valid | output | 1 | Serial bit offered |
| tx_line_ready | input | 1 | Serial bit taken |
| rx_line_bit | input | 1 | Serial bit in |
| rx_line_end | input | 1 | Bit is the last of the frame |
| rx_line_valid | input | 1 | Serial bit offered |
| rx_line_ready | output | 1 | Serial bit taken |
| rx_crc_en | input | 1 | Check CRC for this frame (sampled with start bit) |
| rx_out_data | output | 8 | Received byte |
| rx_out_valid | output | 1 | Received byte offered |
| rx_out_ready | input | 1 | Received byte taken |
| rx_stat_valid | output | 1 | End-of-frame status pulse |
| rx_stat_par | output | 1 | Parity error seen |
| rx_stat_crc | output | 1 | CRC residue nonzero |
| rx_stat_len | output | 1 | Bit count not 1 plus a multiple of 9 |
| rx_stat_long | output | 1 | Frame aborted for exceeding 163 bits |

## Verification
The transmitter is tried with an all-zero payload that has a known CRC, which pins down the polynomial, seed and byte order. It is also fed a mixed payload under a stalling line, which exposes bit-order, parity and hold faults. Two over-long byte streams, one with CRC and one without, show whether the frame closes at the right byte. The receiver gets a clean CRC frame plus variants with one parity bit flipped, a damaged CRC byte and four stray bits, so each error flag is told apart from the others. It also gets an exactly full frame against a frame one byte too long, and a run with the byte consumer held off.

// File: rtl/parity_frame_codec.sv
module parity_frame_codec #(
  parameter int MAX_BYTES = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_in_data,
  input  logic       tx_in_last,
  input  logic       tx_in_crc,
  input  logic       tx_in_valid,
  output logic       tx_in_ready,
  output logic       tx_line_bit,
  output logic       tx_line_end,
  output logic       tx_line_valid,
  input  logic       tx_line_ready,
  input  logic       rx_line_bit,
  input  logic       rx_line_end,
  input  logic       rx_line_valid,
  output logic       rx_line_ready,
  input  logic       rx_crc_en,
  output logic [7:0] rx_out_data,
  output logic       rx_out_valid,
  input  logic       rx_out_ready,
  output logic       rx_stat_valid,
  output logic       rx_stat_par,
  output logic       rx_stat_crc,
  output logic       rx_stat_len,
  output logic       rx_stat_long
);
  localparam int          MAX_BITS = 1 + 9 * MAX_BYTES;
  localparam int          CW       = $clog2(MAX_BITS + 1);
  localparam int          NB       = $clog2(MAX_BYTES + 1);
  localparam logic [15:0] SEED     = 16'h6363;
  localparam logic [15:0] POLY     = 16'h8408;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ POLY) : (x >> 1);
    return x;
  endfunction

  // ---------------- transmit ----------------
  typedef enum logic [1:0] {T_IDLE, T_START, T_LOAD, T_BITS} tstate_e;
  tstate_e       t_st;
  logic [8:0]    t_sh;
  logic [3:0]    t_cnt;
  logic          t_fin, t_lastdata, t_hi_pend, t_crc_on;
  logic [15:0]   t_crc;
  logic [NB-1:0] t_nbytes, t_cap_m1;
  logic          t_fire, t_load, t_le;

  assign tx_in_ready   = (t_st == T_LOAD);
  assign tx_line_valid = (t_st == T_START) || (t_st == T_BITS);
  assign tx_line_bit   = (t_st == T_START) ? 1'b1 : t_sh[0];
  assign tx_line_end   = (t_st == T_BITS) && (t_cnt == 4'd0) && t_fin;
  assign t_fire        = tx_line_valid && tx_line_ready;
  assign t_load        = tx_in_ready && tx_in_valid;
  assign t_cap_m1      = t_crc_on ? NB'(MAX_BYTES - 3) : NB'(MAX_BYTES - 1);
  assign t_le          = tx_in_last || (t_nbytes == t_cap_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_st <= T_IDLE; t_sh <= '0; t_cnt <= '0; t_fin <= 1'b0;
      t_lastdata <= 1'b0; t_hi_pend <= 1'b0; t_crc_on <= 1'b0;
      t_crc <= SEED; t_nbytes <= '0;
    end else begin
      case (t_st)
        T_IDLE: if (tx_in_valid) begin
          t_crc_on <= tx_in_crc; t_crc <= SEED; t_nbytes <= '0;
          t_hi_pend <= 1'b0; t_st <= T_START;
        end
        T_START: if (t_fire) t_st <= T_LOAD;
        T_LOAD: if (t_load) begin
          t_sh       <= {~^tx_in_data, tx_in_data};
          t_cnt      <= 4'd8;
          t_crc      <= crc_step(t_crc, tx_in_data);
          t_nbytes   <= t_nbytes + 1'b1;
          t_fin      <= t_le && !t_crc_on;
          t_lastdata <= t_le && t_crc_on;
          t_st       <= T_BITS;
        end
        T_BITS: if (t_fire) begin
          if (t_cnt != 4'd0) begin
            t_sh  <= t_sh >> 1;
            t_cnt <= t_cnt - 1'b1;
          end else if (t_fin) begin
            t_fin <= 1'b0; t_st <= T_IDLE;
          end else if (t_lastdata) begin
            t_sh <= {~^t_crc[7:0], t_crc[7:0]}; t_cnt <= 4'd8;
            t_lastdata <= 1'b0; t_hi_pend <= 1'b1;
          end else if (t_hi_pend) begin
            t_sh <= {~^t_crc[15:8], t_crc[15:8]}; t_cnt <= 4'd8;
            t_hi_pend <= 1'b0; t_fin <= 1'b1;
          end else begin
            t_st <= T_LOAD;
          end
        end
        default: t_st <= T_IDLE;
      endcase
    end
  end

  // ---------------- receive ----------------
  typedef enum logic [1:0] {R_IDLE, R_DATA, R_DRAIN} rstate_e;
  rstate_e     r_st;
  logic [CW-1:0] r_cnt;
  logic [3:0]  r_pos, r_pos_nx;
  logic [7:0]  r_sh;
  logic        r_par, r_perr, r_crc_on;
  logic [15:0] r_crc, r_crc_nx;
  logic        r_fire, r_bytedone, r_perr_nx;

  assign rx_line_ready = !(rx_out_valid && !rx_out_ready);
  assign r_fire        = rx_line_valid && rx_line_ready;
  assign r_bytedone    = (r_pos == 4'd8);
  assign r_crc_nx      = r_bytedone ? crc_step(r_crc, r_sh) : r_crc;
  assign r_perr_nx     = r_perr | (r_bytedone & ~(r_par ^ rx_line_bit));
  assign r_pos_nx      = r_bytedone ? 4'd0 : r_pos + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_st <= R_IDLE; r_cnt <= '0; r_pos <= '0; r_sh <= '0;
      r_par <= 1'b0; r_perr <= 1'b0; r_crc_on <= 1'b0; r_crc <= SEED;
      rx_out_data <= '0; rx_out_valid <= 1'b0;
      rx_stat_valid <= 1'b0; rx_stat_par <= 1'b0; rx_stat_crc <= 1'b0;
      rx_stat_len <= 1'b0; rx_stat_long <= 1'b0;
    end else begin
      rx_stat_valid <= 1'b0;
      if (rx_out_valid && rx_out_ready) rx_out_valid <= 1'b0;
      if (r_fire) begin
        case (r_st)
          R_IDLE: begin
            r_cnt <= CW'(1); r_pos <= '0; r_par <= 1'b0; r_perr <= 1'b0;
            r_crc <= SEED; r_crc_on <= rx_crc_en;
            if (rx_line_end) begin
              rx_stat_valid <= 1'b1; rx_stat_par <= 1'b0;
              rx_stat_crc <= rx_crc_en; rx_stat_len <= 1'b0; rx_stat_long <= 1'b0;
            end else begin
              r_st <= R_DATA;
            end
          end
          R_DATA: begin
            if (r_cnt == CW'(MAX_BITS)) begin
              rx_stat_valid <= 1'b1; rx_stat_par <= r_perr;
              rx_stat_crc <= 1'b0; rx_stat_len <= 1'b0; rx_stat_long <= 1'b1;
              r_st <= rx_line_end ? R_IDLE : R_DRAIN;
            end else begin
              r_cnt  <= r_cnt + 1'b1;
              r_pos  <= r_pos_nx;
              r_crc  <= r_crc_nx;
              r_perr <= r_perr_nx;
              if (r_bytedone) begin
                rx_out_data <= r_sh; rx_out_valid <= 1'b1; r_par <= 1'b0;
              end else begin
                r_sh <= {rx_line_bit, r_sh[7:1]}; r_par <= r_par ^ rx_line_bit;
              end
              if (rx_line_end) begin
                rx_stat_valid <= 1'b1; rx_stat_par <= r_perr_nx;
                rx_stat_crc   <= r_crc_on && (r_crc_nx != 16'h0000);
                rx_stat_len   <= (r_pos_nx != 4'd0); rx_stat_long <= 1'b0;
                r_st <= R_IDLE;
              end
            end
          end
          R_DRAIN: if (rx_line_end) r_st <= R_IDLE;
          default: r_st <= R_IDLE;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  p_no_load_while_sending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_ready |-> !tx_line_valid);
  p_idle_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_line_valid && tx_line_ready && tx_line_end |=> !tx_line_valid);
  p_line_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_line_valid && !tx_line_ready |=> tx_line_valid && $stable(tx_line_bit) && $stable(tx_line_end));
  p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    r_cnt <= CW'(MAX_BITS));
  p_long_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stat_valid && rx_stat_long |-> !rx_stat_len && !rx_stat_crc);
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_data));
endmodule

// File: tb/parity_frame_codec_tb.sv
`timescale 1ns/100ps
module parity_frame_codec_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic tx_in_last = 0, tx_in_crc = 0, tx_in_valid = 0, tx_in_ready;
  logic tx_line_bit, tx_line_end, tx_line_valid, tx_line_ready = 1;
  logic rx_line_bit = 0, rx_line_end = 0, rx_line_valid = 0, rx_line_ready, rx_crc_en = 0;
  logic [7:0] rx_out_data;
  logic rx_out_valid, rx_out_ready = 1;
  logic rx_stat_valid, rx_stat_par, rx_stat_crc, rx_stat_len, rx_stat_long;

  always #2.5 clk = ~clk;

  parity_frame_codec dut_i (.*);

  int n_chk = 0, n_bad = 0, cyc = 0, hold_bad = 0;
  bit stall_on = 0, done = 0;
  bit tx_bits[$];
  int tx_ends[$];
  logic [7:0] rx_got[$];
  int rx_st[$];
  bit rxv[$];
  bit held_v = 0, held_b = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc16(input logic [7:0] b[$]);
    logic [15:0] c = 16'h6363;
    foreach (b[i]) begin
      c ^= {8'h00, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  always @(posedge clk) begin
    #1; cyc++;
    if (stall_on) tx_line_ready = (cyc % 3) != 0;
  end

  always @(negedge clk) begin
    if (held_v && !(tx_line_valid && tx_line_bit == held_b)) hold_bad++;
    held_v = tx_line_valid && !tx_line_ready;
    held_b = tx_line_bit;
    if (tx_line_valid && tx_line_ready) begin
      tx_bits.push_back(tx_line_bit);
      if (tx_line_end) tx_ends.push_back(tx_bits.size());
    end
    if (rx_out_valid && rx_out_ready) rx_got.push_back(rx_out_data);
    if (rx_stat_valid) rx_st.push_back({28'd0, rx_stat_long, rx_stat_len, rx_stat_crc, rx_stat_par});
  end

  task automatic push_byte(input logic [7:0] d, input bit last, input bit crc);
    tx_in_data = d; tx_in_last = last; tx_in_crc = crc; tx_in_valid = 1;
    do @(negedge clk); while (!tx_in_ready);
    @(posedge clk); #1;
    tx_in_valid = 0;
  endtask

  task automatic run_tx(input logic [7:0] d[$], input bit crc, input int nfr);
    tx_bits.delete(); tx_ends.delete();
    foreach (d[i]) push_byte(d[i], i == d.size() - 1, crc);
    for (int w = 0; w < 3000 && tx_ends.size() < nfr; w++) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic check_frame(input int k, input logic [7:0] e[$], input string tag);
    int base = (k == 0) ? 0 : tx_ends[k-1];
    int mism = 0, perr = 0;
    if (tx_ends.size() <= k) begin
      chk(0, {tag, " R3 frame end seen"}, tx_ends.size(), k + 1);
      return;
    end
    chk(tx_bits[base] == 1, {tag, " R1 start bit"}, tx_bits[base], 1);
    chk(tx_ends[k] - base == 1 + 9 * e.size(), {tag, " R4 frame bits"}, tx_ends[k] - base, 1 + 9 * e.size());
    for (int j = 0; j < e.size() && base + 9 * j + 9 < tx_ends[k] + 1; j++) begin
      logic [7:0] g;
      bit p;
      for (int b = 0; b < 8; b++) g[b] = tx_bits[base + 1 + 9 * j + b];
      p = tx_bits[base + 9 + 9 * j];
      if (g != e[j]) mism++;
      if (((^g) ^ p) != 1'b1) perr++;
    end
    chk(mism == 0, {tag, " R1 byte order and bit order"}, mism, 0);
    chk(perr == 0, {tag, " R2 odd parity"}, perr, 0);
  endtask

  task automatic rx_add(input logic [7:0] d, input bit flip);
    for (int b = 0; b < 8; b++) rxv.push_back(d[b]);
    rxv.push_back((~^d) ^ flip);
  endtask

  task automatic rx_send(input bit crc_en);
    rx_got.delete(); rx_st.delete();
    rx_crc_en = crc_en;
    foreach (rxv[i]) begin
      rx_line_valid = 1; rx_line_bit = rxv[i]; rx_line_end = (i == rxv.size() - 1);
      do @(negedge clk); while (!rx_line_ready);
      @(posedge clk); #1;
    end
    rx_line_valid = 0; rx_line_end = 0;
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic rx_frame(input logic [7:0] d[$], input bit add_crc, input int flip_at, input int extra);
    logic [15:0] c = crc16(d);
    rxv.delete(); rxv.push_back(1'b1);
    foreach (d[i]) rx_add(d[i], i == flip_at);
    if (add_crc) begin rx_add(c[7:0], 0); rx_add(c[15:8], 0); end
    for (int i = 0; i < extra; i++) rxv.push_back(i[0]);
  endtask

  task automatic t_reset;
    chk(tx_line_valid == 0, "R12 tx_line_valid", tx_line_valid, 0);
    chk(tx_in_ready == 0, "R12 tx_in_ready", tx_in_ready, 0);
    chk(rx_out_valid == 0 && rx_stat_valid == 0, "R12 rx outputs", rx_out_valid, 0);
    chk(rx_line_ready == 1, "R12 rx_line_ready", rx_line_ready, 1);
  endtask

  task automatic t_tx_known;
    logic [7:0] d[$] = '{8'h00, 8'h00};
    logic [7:0] e[$] = '{8'h00, 8'h00, 8'hA0, 8'h1E};
    run_tx(d, 1, 1);
    check_frame(0, e, "zero-crc R3");
    chk(tx_ends.size() == 1, "R3 single end marker", tx_ends.size(), 1);
  endtask

  task automatic t_tx_stall;
    logic [7:0] d[$] = '{8'h5A, 8'hFF, 8'h01, 8'h80, 8'h37};
    hold_bad = 0; stall_on = 1;
    run_tx(d, 0, 1);
    stall_on = 0; tx_line_ready = 1;
    check_frame(0, d, "stalled");
    chk(hold_bad == 0, "R5 bit held while stalled", hold_bad, 0);
  endtask

  task automatic t_tx_cap;
    logic [7:0] d[$], f1[$], f2[$];
    logic [15:0] c;
    for (int i = 0; i < 20; i++) d.push_back(8'(i * 13 + 1));
    run_tx(d, 0, 2);
    f1 = d[0:17]; f2 = d[18:19];
    chk(tx_ends.size() == 2, "R4 frames without crc", tx_ends.size(), 2);
    check_frame(0, f1, "cap-nocrc R4");
    check_frame(1, f2, "cap-rest R4");
    d.delete(); f1.delete(); f2.delete();
    for (int i = 0; i < 17; i++) d.push_back(8'(i * 7 + 3));
    run_tx(d, 1, 2);
    f1 = d[0:15]; c = crc16(f1); f1.push_back(c[7:0]); f1.push_back(c[15:8]);
    f2.push_back(d[16]); c = crc16(f2); f2.push_back(c[7:0]); f2.push_back(c[15:8]);
    check_frame(0, f1, "cap-crc R4");
    check_frame(1, f2, "cap-crc-rest R3");
  endtask

  task automatic rx_expect(input logic [7:0] e[$], input int st, input string tag);
    int mism = 0;
    chk(rx_got.size() == e.size(), {tag, " R6 byte count"}, rx_got.size(), e.size());
    foreach (e[i]) if (i < rx_got.size() && rx_got[i] != e[i]) mism++;
    chk(mism == 0, {tag, " R6 byte values"}, mism, 0);
    chk(rx_st.size() == 1, {tag, " R6 one status"}, rx_st.size(), 1);
    if (rx_st.size() > 0) chk(rx_st[0] == st, {tag, " status {long,len,crc,par}"}, rx_st[0], st);
  endtask

  task automatic t_rx_good;
    logic [7:0] d[$] = '{8'h30, 8'h04, 8'hC7};
    logic [7:0] e[$];
    logic [15:0] c = crc16(d);
    e = d; e.push_back(c[7:0]); e.push_back(c[15:8]);
    rx_frame(d, 1, -1, 0); rx_send(1);
    rx_expect(e, 0, "clean R8");
  endtask

  task automatic t_rx_parity;
    logic [7:0] d[$] = '{8'h30, 8'h04, 8'hC7};
    logic [7:0] e[$];
    logic [15:0] c = crc16(d);
    e = d; e.push_back(c[7:0]); e.push_back(c[15:8]);
    rx_frame(d, 1, 1, 0); rx_send(1);
    rx_expect(e, 1, "parity R7");
  endtask

  task automatic t_rx_crcbad;
    logic [7:0] d[$] = '{8'h11, 8'h22, 8'h33, 8'h44};
    rxv.delete(); rxv.push_back(1'b1);
    foreach (d[i]) rx_add(d[i], 0);
    rx_add(8'h00, 0); rx_add(8'h00, 0);
    d.push_back(8'h00); d.push_back(8'h00);
    rx_send(1);
    rx_expect(d, 2, "bad-crc R8");
  endtask

  task automatic t_rx_len;
    logic [7:0] d[$] = '{8'hA5, 8'h3C};
    rx_frame(d, 0, -1, 4); rx_send(0);
    rx_expect(d, 4, "partial R9");
  endtask

  task automatic t_rx_nocrc;
    logic [7:0] d[$] = '{8'h26};
    rx_frame(d, 0, -1, 0); rx_send(0);
    rx_expect(d, 0, "short no-crc R8");
  endtask

  task automatic t_rx_long;
    logic [7:0] d[$], e[$];
    for (int i = 0; i < 19; i++) d.push_back(8'(i * 29 + 5));
    e = d[0:17];
    rx_frame(e, 0, -1, 0); rx_send(0);
    rx_expect(e, 0, "exact-163 R10");
    rx_frame(d, 0, -1, 0); rx_send(0);
    rx_expect(e, 8, "over-length R10");
    t_rx_good();
  endtask

  task automatic t_rx_backpressure;
    logic [7:0] d[$] = '{8'h9E, 8'h01, 8'h7F};
    logic [7:0] e[$];
    logic [15:0] c = crc16(d);
    int lo = 0;
    e = d; e.push_back(c[7:0]); e.push_back(c[15:8]);
    rx_frame(d, 1, -1, 0);
    rx_out_ready = 0;
    fork
      rx_send(1);
      begin
        repeat (40) begin @(negedge clk); if (!rx_line_ready) lo++; end
        @(posedge clk); #1; rx_out_ready = 1;
      end
    join
    chk(lo > 0, "R11 line stalled while byte held", lo, 1);
    rx_expect(e, 0, "backpressure R11");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    t_reset();
    @(posedge clk); #1;
    t_tx_known();
    t_tx_stall();
    t_tx_cap();
    t_rx_good();
    t_rx_parity();
    t_rx_crcbad();
    t_rx_len();
    t_rx_nocrc();
    t_rx_long();
    t_rx_backpressure();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule